// File: doc/BRIEF.md
# Sample Buffer with Watermark and Overflow Policy

This block stores byte-wide measurement samples in a 32-entry first-in first-out buffer that a host drains through a single read port. A setup byte, applied as a level on an input port, selects both the overflow policy and a watermark level. The policy decides what happens to a sample that arrives when every slot is occupied. In circular mode the oldest sample is discarded so that the buffer always holds the newest ones. In stop mode the new sample is dropped so that the buffer keeps the earliest ones. A third setting turns sample capture off.

A status byte reports how many samples are held, whether the watermark level has been reached, and whether an overflow has occurred since the status was last read. The block raises an interrupt request while either event flag is set. An eight-bit tick counter starts at the first overflow after reset and stops at its ceiling, which tells the host roughly how long ago samples began to be lost.

Top module: `sample_fifo`

## Requirements
- R1: During and right after synchronous active-low reset, the buffer is empty, `rd_data` is 0, `status` is 0, `fifo_irq` is 0 and `ovf_ticks` is 0.
- R2: When `setup[7:6]` is 00 or 11, `smp_wr` is ignored. The count does not change and no overflow is flagged.
- R3: A `host_rd` pulse on a non-empty buffer removes the oldest sample and shows it on `rd_data` from the following clock edge. Samples come out in write order. A read of an empty buffer leaves `rd_data` and the count unchanged.
- R4: `status[5:0]` equals the number of samples held, from 0 to 32. It never exceeds 32.
- R5: In circular mode (`setup[7:6]` = 01), a write to a full buffer discards the oldest sample and stores the new one. The count stays at 32.
- R6: In stop mode (`setup[7:6]` = 10), a write to a full buffer is dropped. Contents and count are unchanged.
- R7: `status[7]` sets on the edge after a write attempt to a full buffer in mode 01 or 10. It stays set until a `stat_rd` pulse. When a new overflow and a `stat_rd` pulse occur in the same cycle, the flag stays set.
- R8: `status[6]` is 1 exactly when `setup[5:0]` is nonzero and the held count is at least `setup[5:0]`. A watermark of 0 never sets it.
- R9: `fifo_irq` is 1 exactly when `status[7]` or `status[6]` is 1.
- R10: `ovf_ticks` stays 0 until the first overflow event after reset. It reads 0 on the edge of that event, then rises by 1 per clock and holds at 255. Later overflows and `stat_rd` do not restart it.
- R11: A read and a write in the same cycle both take effect. In circular mode at full, the read returns the oldest sample and the count stays 32. In stop mode at full, the read is served and the write is still dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| smp_wr | input | 1 | Sample write strobe |
| smp_data | input | 8 | Sample to store |
| host_rd | input | 1 | Data-port read strobe |
| stat_rd | input | 1 | Status read strobe; clears the overflow flag |
| setup | input | 8 | [7:6] policy (00 off, 01 circular, 10 stop, 11 off), [5:0] watermark |
| rd_data | output | 8 | Last sample removed by a read |
| status | output | 8 | [7] overflow flag, [6] watermark flag, [5:0] sample count |
| fifo_irq | output | 1 | Interrupt request |
| ovf_ticks | output | 8 | Clocks since the first overflow, saturating |

## Verification
The bench targets the full boundary under both policies.

- A wrong discard rule would appear as a stale oldest sample in circular mode, or as a corrupted tail in stop mode.
- A design that let a simultaneous read make room for a stop-mode write would show a count one higher than the model.
- A flag-clear priority error would lose an overflow raised in the same cycle as a status read.
- A watermark decoded with a greater-than test, or one that fires for a zero level, would disagree with the model at the exact threshold count.
- The tick counter is driven well past its ceiling and through later overflows, to expose a counter that wraps or restarts.

// File: rtl/sfifo_pkg.sv
// Shared definitions for the sample buffer: policy encoding and field widths.
package sfifo_pkg;
    // Overflow policy carried in setup[7:6]
    typedef enum logic [1:0] {
        POL_OFF  = 2'b00,
        POL_CIRC = 2'b01,
        POL_STOP = 2'b10,
        POL_OFF3 = 2'b11
    } pol_e;

    localparam int STAT_CNT_W = 6;   // count field width in the status byte
    localparam int WM_W       = 6;   // watermark field width in the setup byte
endpackage

// File: rtl/sfifo_store.sv
// Storage and pointer control for the sample buffer.
// Assumes DEPTH is a power of two so the pointers wrap naturally.
// A read at full in stop mode does not make room for a write in the same cycle.
module sfifo_store
    import sfifo_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int DW    = 8,
    localparam int PW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  pol_e          policy,
    input  logic          wr_req,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_req,
    output logic [DW-1:0] rd_data,
    output logic [CW-1:0] count,
    output logic          ovf_evt
);
    logic [DW-1:0] mem [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic          full, empty, cap_on, do_pop, do_push, drop_old, adv_rd;

    // Decode this cycle's pushes, pops and overwrite
    always_comb begin
        full     = (count == CW'(DEPTH));
        empty    = (count == '0);
        cap_on   = (policy == POL_CIRC) || (policy == POL_STOP);
        do_pop   = rd_req && !empty;
        do_push  = wr_req && cap_on && (!full || policy == POL_CIRC);
        drop_old = do_push && full && !do_pop;
        adv_rd   = do_pop || drop_old;
        ovf_evt  = wr_req && cap_on && full;
    end

    // Sample array write port
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= wr_data;
    end

    // Pointers, occupancy and the registered read data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            count   <= '0;
            rd_data <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + 1'b1;
            if (adv_rd)  rd_ptr <= rd_ptr + 1'b1;
            if (do_pop)  rd_data <= mem[rd_ptr];
            count <= count + CW'(do_push) - CW'(adv_rd);
        end
    end

    a_r4_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));
    a_r2_off_no_growth: assert property (@(posedge clk) disable iff (!rst_n)
        (policy == POL_OFF || policy == POL_OFF3) |=> count <= $past(count));
    a_r5_circ_stays_full: assert property (@(posedge clk) disable iff (!rst_n)
        (policy == POL_CIRC && count == CW'(DEPTH) && wr_req) |=> count == CW'(DEPTH));
    a_r6_stop_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (policy == POL_STOP && count == CW'(DEPTH) && wr_req && !rd_req)
            |=> (count == CW'(DEPTH)) && $stable(wr_ptr));
endmodule

// File: rtl/sfifo_flags.sv
// Event flags and status packing for the sample buffer.
// The overflow flag is sticky and is cleared by a status read. A new
// overflow in the same cycle wins over the clear. The watermark flag is a
// live compare against the current setup level.
module sfifo_flags
    import sfifo_pkg::*;
#(
    parameter int CW = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ovf_evt,
    input  logic            stat_rd,
    input  logic [CW-1:0]   count,
    input  logic [WM_W-1:0] wm_level,
    output logic [7:0]      status,
    output logic            irq
);
    logic                  ovf_flag, wm_flag;
    logic [STAT_CNT_W-1:0] cnt_field;

    // Sticky overflow flag with set priority
    always_ff @(posedge clk) begin
        if (!rst_n)        ovf_flag <= 1'b0;
        else if (ovf_evt)  ovf_flag <= 1'b1;
        else if (stat_rd)  ovf_flag <= 1'b0;
    end

    // Watermark compare and status assembly
    always_comb begin
        cnt_field = STAT_CNT_W'(count);
        wm_flag   = (wm_level != '0) && (cnt_field >= wm_level);
        status    = {ovf_flag, wm_flag, cnt_field};
        irq       = ovf_flag | wm_flag;
    end

    a_r7_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (status[7] && !stat_rd) |=> status[7]);
    a_r7_ovf_sets: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_evt |=> status[7]);
endmodule

// File: rtl/sfifo_ovf_timer.sv
// Counts clocks since the first overflow after reset and saturates at its
// maximum. Assumes later overflows must not restart it.
module sfifo_ovf_timer #(
    parameter int TW = 8,
    localparam logic [TW-1:0] TMAX = '1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ovf_evt,
    output logic [TW-1:0] ticks
);
    logic running;

    // Arm on the first overflow, then count up to the ceiling
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running <= 1'b0;
            ticks   <= '0;
        end else if (!running) begin
            if (ovf_evt) running <= 1'b1;
            ticks <= '0;
        end else if (ticks != TMAX) begin
            ticks <= ticks + 1'b1;
        end
    end

    a_r10_tick_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (ticks == TMAX) |=> (ticks == TMAX));
    a_r10_tick_step: assert property (@(posedge clk) disable iff (!rst_n)
        (ticks != '0 && ticks != TMAX) |=> (ticks == $past(ticks) + 1'b1));
endmodule

// File: rtl/sample_fifo.sv
// Sample buffer top: splits the setup byte into policy and watermark, and
// ties the storage, flag and timer pieces together.
module sample_fifo
    import sfifo_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int TW    = 8,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          smp_wr,
    input  logic [7:0]    smp_data,
    input  logic          host_rd,
    input  logic          stat_rd,
    input  logic [7:0]    setup,
    output logic [7:0]    rd_data,
    output logic [7:0]    status,
    output logic          fifo_irq,
    output logic [TW-1:0] ovf_ticks
);
    pol_e          policy;
    logic [CW-1:0] count;
    logic          ovf_evt;

    assign policy = pol_e'(setup[7:6]);

    sfifo_store #(.DEPTH(DEPTH), .DW(8)) u_store (
        .clk(clk), .rst_n(rst_n), .policy(policy),
        .wr_req(smp_wr), .wr_data(smp_data), .rd_req(host_rd),
        .rd_data(rd_data), .count(count), .ovf_evt(ovf_evt)
    );

    sfifo_flags #(.CW(CW)) u_flags (
        .clk(clk), .rst_n(rst_n), .ovf_evt(ovf_evt), .stat_rd(stat_rd),
        .count(count), .wm_level(setup[WM_W-1:0]),
        .status(status), .irq(fifo_irq)
    );

    sfifo_ovf_timer #(.TW(TW)) u_timer (
        .clk(clk), .rst_n(rst_n), .ovf_evt(ovf_evt), .ticks(ovf_ticks)
    );

    a_r9_irq_src: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_irq |-> (status[7] || status[6]));
endmodule

// File: tb/sample_fifo_test.sv
`timescale 1ns/1ps
module sample_fifo_test;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       smp_wr, host_rd, stat_rd;
    logic [7:0] smp_data, setup;
    logic [7:0] rd_data, status, ovf_ticks;
    logic       fifo_irq;

    int n_chk = 0;
    int n_fail = 0;

    // behavioural reference state
    int q[$];
    int m_rd = 0;
    bit m_ovf = 0;
    bit m_run = 0;
    int m_ticks = 0;

    always #2 clk = ~clk;   // 250 MHz

    sample_fifo uut (
        .clk(clk), .rst_n(rst_n), .smp_wr(smp_wr), .smp_data(smp_data),
        .host_rd(host_rd), .stat_rd(stat_rd), .setup(setup),
        .rd_data(rd_data), .status(status), .fifo_irq(fifo_irq),
        .ovf_ticks(ovf_ticks)
    );

    task automatic chk(string tag, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic compare_all();
        int wm;
        bit exp_wm;
        wm = int'(setup[5:0]);
        exp_wm = (wm != 0) && (q.size() >= wm);
        chk("R3", "rd_data", int'(rd_data), m_rd);
        chk("R4", "count", int'(status[5:0]), q.size());
        chk("R7", "ovf flag", int'(status[7]), int'(m_ovf));
        chk("R8", "wm flag", int'(status[6]), int'(exp_wm));
        chk("R9", "irq", int'(fifo_irq), int'(m_ovf | exp_wm));
        chk("R10", "ticks", int'(ovf_ticks), m_ticks);
    endtask

    // apply one cycle of stimulus at a falling edge, advance the model, compare
    task automatic step(bit w, int d, bit r, bit s);
        int cnt, mode;
        bit full, en, popped, ev;
        smp_wr = w; smp_data = 8'(d); host_rd = r; stat_rd = s;
        cnt = q.size(); full = (cnt == 32);
        mode = int'(setup[7:6]);
        en = (mode == 1) || (mode == 2);
        popped = 0;
        if (r && cnt > 0) begin m_rd = q.pop_front(); popped = 1; end
        ev = w && en && full;
        if (w && en) begin
            if (!full) q.push_back(d & 255);
            else if (mode == 1) begin
                if (!popped) void'(q.pop_front());
                q.push_back(d & 255);
            end
        end
        if (!m_run) begin
            if (ev) begin m_run = 1; m_ticks = 0; end
        end else if (m_ticks < 255) m_ticks++;
        if (ev) m_ovf = 1;
        else if (s) m_ovf = 0;
        @(posedge clk);
        @(negedge clk);
        compare_all();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; smp_wr = 0; host_rd = 0; stat_rd = 0; smp_data = 0; setup = 0;
        repeat (3) @(negedge clk);
        chk("R1", "status at reset", int'(status), 0);
        chk("R1", "rd_data at reset", int'(rd_data), 0);
        chk("R1", "irq at reset", int'(fifo_irq), 0);
        chk("R1", "ticks at reset", int'(ovf_ticks), 0);
        rst_n = 1'b1;
        step(0, 0, 0, 0);

        // R2: disabled modes ignore writes
        setup = 8'h03;
        for (int i = 0; i < 5; i++) step(1, 10 + i, 0, 0);
        setup = 8'hC2;
        for (int i = 0; i < 3; i++) step(1, 20 + i, 0, 0);
        chk("R2", "count after off writes", int'(status[5:0]), 0);
        chk("R2", "no overflow when off", int'(status[7]), 0);

        // R8: watermark threshold in stop mode, level 4
        setup = 8'h84;
        for (int i = 0; i < 3; i++) step(1, 30 + i, 0, 0);
        chk("R8", "below level", int'(status[6]), 0);
        step(1, 33, 0, 0);
        chk("R8", "at level", int'(status[6]), 1);
        chk("R9", "irq at level", int'(fifo_irq), 1);
        step(0, 0, 1, 0);
        chk("R3", "first out", int'(rd_data), 30);
        chk("R8", "below again", int'(status[6]), 0);
        setup = 8'h80;
        for (int i = 0; i < 4; i++) step(0, 0, 1, 0);
        chk("R3", "empty read holds data", int'(rd_data), 33);

        // R6: stop mode at full drops writes
        for (int i = 0; i < 32; i++) step(1, i, 0, 0);
        step(1, 200, 0, 0);
        chk("R6", "count held at full", int'(status[5:0]), 32);
        chk("R7", "overflow set", int'(status[7]), 1);
        chk("R10", "ticks at first event", int'(ovf_ticks), 0);
        step(1, 201, 1, 0);   // R11: stop full, read served, write dropped
        chk("R11", "stop full read", int'(rd_data), 0);
        chk("R11", "stop full count", int'(status[5:0]), 31);
        step(0, 0, 0, 1);
        chk("R7", "cleared by status read", int'(status[7]), 0);
        step(1, 202, 0, 0);
        step(1, 203, 0, 1);   // set wins over clear
        chk("R7", "set wins", int'(status[7]), 1);
        for (int i = 0; i < 32; i++) step(0, 0, 1, 0);
        chk("R6", "last kept sample", int'(rd_data), 202);

        // R5: circular mode keeps the newest samples
        setup = 8'h40;
        for (int i = 0; i < 32; i++) step(1, 100 + i, 0, 0);
        for (int i = 0; i < 5; i++) step(1, 150 + i, 0, 0);
        chk("R5", "count stays full", int'(status[5:0]), 32);
        step(1, 160, 1, 0);   // R11: circular full read+write
        chk("R11", "oldest returned", int'(rd_data), 105);
        chk("R11", "still full", int'(status[5:0]), 32);
        step(0, 0, 1, 0);
        chk("R5", "next oldest", int'(rd_data), 106);
        while (q.size() > 0) step(0, 0, 1, 0);
        chk("R5", "newest last", int'(rd_data), 160);

        // R10: saturation
        for (int i = 0; i < 300; i++) step(0, 0, 0, 0);
        chk("R10", "saturated", int'(ovf_ticks), 255);

        // mixed random traffic with policy changes
        for (int blk = 0; blk < 40; blk++) begin
            setup = 8'($urandom);
            if (setup[5:0] > 6'd40) setup[5:0] = 6'd0;
            for (int i = 0; i < 50; i++)
                step(($urandom % 10) < 7, int'($urandom % 256),
                     ($urandom % 10) < 3, ($urandom % 8) == 0);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule